// File: doc/BRIEF.md
# Single-Digit Decimal Adder with Multiplexed Correction

This block adds two packed decimal digits (four bits each, values 0 to 9) and a carry-in. It returns one decimal sum digit and a decimal carry-out. It is purely combinational. It is meant to be placed once per digit position in a wider decimal datapath, where the carry-out of one digit feeds the carry-in of the next digit up.

The binary sum is formed first. Its carries come from merge cells that each combine two bit positions' propagate/generate pairs with an incoming carry. A small detector then flags any binary result of ten or more. That flag is also the decimal carry-out.

The corrected digit is not made by a second adder. It is derived bit by bit from the intermediate sum: one bit is passed through, one is inverted, and two come from short XOR/OR terms. Multiplexers on the upper three bits pick the raw or the corrected value, with the flag as the select. Inputs outside 0 to 9 give unspecified results.

Top module: `bcd_digit_add`

## Requirements
- R1: When a_i + b_i + cin_i is 0 to 9, cout_o is 0 and sum_o equals that total.
- R2: When a_i + b_i + cin_i is 10 to 19, cout_o is 1 and sum_o equals the total minus 10.
- R3: The carry-out threshold is exactly ten. A total of 9 (for example 9+0+0, or 4+4+1) gives cout_o = 0, and a total of 10 (for example 9+0+1, or 5+5+0) gives cout_o = 1.
- R4: sum_o[0] always equals a_i[0] XOR b_i[0] XOR cin_i. The least significant bit is never altered by the correction.
- R5: For every pair of valid digits and either carry-in, sum_o is a valid digit from 0 to 9.
- R6: Raising cin_i from 0 to 1 with a_i and b_i held fixed raises the decimal value 10*cout_o + sum_o by exactly one. This covers the extreme 9+9+1 = 19 (cout_o = 1, sum_o = 9).
- R7: The block holds no state. The outputs follow a change of the inputs within the same time step, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First decimal digit, binary-coded, 0 to 9 |
| b_i | input | 4 | Second decimal digit, binary-coded, 0 to 9 |
| cin_i | input | 1 | Decimal carry from the digit below |
| sum_o | output | 4 | Decimal sum digit, binary-coded |
| cout_o | output | 1 | Decimal carry to the digit above |

## Verification
The hardest cases to reach are those where the binary carry out of the four-bit stage is set. Only totals 16 to 19 produce it (for example 9+9+1 and 8+8+0), and there the corrected bits come from a wrapped intermediate value. The other hard cases are the threshold totals 9 and 10. The stimulus sweeps all 100 valid digit pairs with each carry-in value, so every one of these cases is applied. It also re-applies the threshold and extreme pairs with carry-in toggled back to back, to compare neighbouring results.

// File: rtl/bcd_digit_pkg.sv
package bcd_digit_pkg;
  parameter int DIG_W = 4;
  localparam int MAX_DIGIT = 9;

  typedef logic [DIG_W-1:0] digit_t;

  typedef struct packed {
    logic p;
    logic g;
  } pg_t;
endpackage

// File: rtl/bcd_cm_cell.sv
// Merges two bit positions' propagate/generate with an incoming carry.
module bcd_cm_cell
  import bcd_digit_pkg::*;
(
  input  pg_t  lo_i,
  input  pg_t  hi_i,
  input  logic c_i,
  output logic c_o
);
  assign c_o = hi_i.g | (hi_i.p & (lo_i.g | (lo_i.p & c_i)));
endmodule

// File: rtl/bcd_bin_stage.sv
module bcd_bin_stage
  import bcd_digit_pkg::*;
(
  input  digit_t a_i,
  input  digit_t b_i,
  input  logic   cin_i,
  output digit_t s_o,
  output logic   c_o
);
  localparam int PAIRS = DIG_W / 2;

  pg_t           pg [DIG_W];
  logic [DIG_W:0] c;

  assign c[0] = cin_i;

  for (genvar i = 0; i < DIG_W; i++) begin : g_pg
    assign pg[i].p = a_i[i] ^ b_i[i];
    assign pg[i].g = a_i[i] & b_i[i];
    assign s_o[i]  = pg[i].p ^ c[i];
  end

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    // odd carry from the low bit alone, even carry merged over the pair
    assign c[2*k+1] = pg[2*k].g | (pg[2*k].p & c[2*k]);
    bcd_cm_cell u_cm (
      .lo_i (pg[2*k]),
      .hi_i (pg[2*k+1]),
      .c_i  (c[2*k]),
      .c_o  (c[2*k+2])
    );
  end

  assign c_o = c[DIG_W];
endmodule

// File: rtl/bcd_ovf_detect.sv
module bcd_ovf_detect
  import bcd_digit_pkg::*;
(
  input  digit_t s_i,
  input  logic   c_i,
  output logic   ovf_o
);
  // binary result >= 10
  assign ovf_o = c_i | (s_i[3] & (s_i[2] | s_i[1]));
endmodule

// File: rtl/bcd_fix_sel.sv
module bcd_fix_sel
  import bcd_digit_pkg::*;
(
  input  digit_t s_i,
  input  logic   ovf_i,
  output digit_t d_o
);
  digit_t fix;

  // low four bits of s + 6, without an adder
  assign fix[0] = s_i[0];
  assign fix[1] = ~s_i[1];
  assign fix[2] = ~(s_i[2] ^ s_i[1]);
  assign fix[3] = s_i[3] ^ (s_i[2] | s_i[1]);

  assign d_o[0] = s_i[0];
  for (genvar i = 1; i < DIG_W; i++) begin : g_mux
    assign d_o[i] = ovf_i ? fix[i] : s_i[i];
  end
endmodule

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
  import bcd_digit_pkg::*;
(
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       cin_i,
  output logic [3:0] sum_o,
  output logic       cout_o
);
  digit_t s_bin;
  logic   c_bin;
  logic   ovf;

  bcd_bin_stage u_bin (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (cin_i),
    .s_o   (s_bin),
    .c_o   (c_bin)
  );

  bcd_ovf_detect u_ovf (
    .s_i   (s_bin),
    .c_i   (c_bin),
    .ovf_o (ovf)
  );

  bcd_fix_sel u_fix (
    .s_i   (s_bin),
    .ovf_i (ovf),
    .d_o   (sum_o)
  );

  assign cout_o = ovf;
endmodule

// File: rtl/bcd_digit_add_chk.sv
module bcd_digit_add_chk (
  input logic [3:0] a_i,
  input logic [3:0] b_i,
  input logic       cin_i,
  input logic [3:0] sum_o,
  input logic       cout_o
);
  logic [4:0] tot;
  logic       valid;

  assign tot   = {1'b0, a_i} + {1'b0, b_i} + {4'b0, cin_i};
  assign valid = (a_i <= 4'd9) && (b_i <= 4'd9);

  always_comb begin
    if (valid) begin
      if (tot <= 5'd9) begin
        assert_low_total_R1: assert ({1'b0, sum_o} == tot)
          else $error("R1 sum mismatch");
      end else begin
        assert_high_total_R2: assert ({1'b0, sum_o} == tot - 5'd10)
          else $error("R2 sum mismatch");
      end
      assert_no_overflow_R3: assert (cout_o == (tot >= 5'd10))
        else $error("R3 carry threshold");
      assert_lsb_parity_R4: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ cin_i))
        else $error("R4 lsb");
      assert_digit_range_R5: assert (sum_o <= 4'd9)
        else $error("R5 range");
    end
  end
endmodule

bind bcd_digit_add bcd_digit_add_chk u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_o  (sum_o),
  .cout_o (cout_o)
);

// File: tb/sim_bcd_digit_add.sv
`timescale 1ns/1ps
module sim_bcd_digit_add;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] a, b, sum;
  logic       cin, cout;

  int checks = 0;
  int errors = 0;
  int q_exp[$];

  always #10 clk = ~clk;

  bcd_digit_add u0 (
    .a_i    (a),
    .b_i    (b),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
               req, a, b, cin, act, exp);
    end
  endtask

  // drive at the rising edge, compare at the falling edge
  task automatic apply(input int av, input int bv, input int cv);
    int tot;
    @(posedge clk);
    a = av[3:0]; b = bv[3:0]; cin = cv[0];
    tot = av + bv + cv;
    q_exp.push_back(tot);
    @(negedge clk);
    begin
      int e = q_exp.pop_front();
      if (e <= 9) begin
        check("R1 cout", int'(cout), 0);
        check("R1 sum", int'(sum), e);
      end else begin
        check("R2 cout", int'(cout), 1);
        check("R2 sum", int'(sum), e - 10);
      end
      check("R4 lsb", int'(sum[0]), (av ^ bv ^ cv) & 1);
      check("R5 range", int'(sum <= 4'd9), 1);
    end
  endtask

  function automatic int dec_val();
    return 10 * int'(cout) + int'(sum);
  endfunction

  task automatic pair_step(input int av, input int bv);
    int v0;
    apply(av, bv, 0);
    v0 = dec_val();
    apply(av, bv, 1);
    check("R6 cin step", dec_val(), v0 + 1);
  endtask

  task automatic threshold(input int av, input int bv, input int cv, input int exp_c);
    apply(av, bv, cv);
    check("R3 threshold", int'(cout), exp_c);
  endtask

  initial begin
    a = 4'd0; b = 4'd0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 idle sum", int'(sum), 0);
    check("R1 idle cout", int'(cout), 0);

    // R7: outputs follow the inputs inside one time step
    #1 a = 4'd7; b = 4'd6; cin = 1'b1;
    #0.1;
    check("R7 settle sum", int'(sum), 4);
    check("R7 settle cout", int'(cout), 1);

    threshold(9, 0, 0, 0);
    threshold(4, 4, 1, 0);
    threshold(9, 0, 1, 1);
    threshold(5, 5, 0, 1);
    threshold(8, 8, 0, 1);

    pair_step(9, 9);
    pair_step(9, 0);
    pair_step(0, 0);
    pair_step(4, 5);

    for (int i = 0; i <= 9; i++)
      for (int j = 0; j <= 9; j++)
        for (int c = 0; c <= 1; c++)
          apply(i, j, c);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule